// File: doc/BRIEF.md
# Dual and Quad Line Read Sequencer

This block sits in the slave side of a serial flash interface and handles the fast read commands that move the address and the returned data over two or four lines at once. A transaction opens when chip select falls. The opcode is shifted in on line 0 at one bit per clock. Two opcodes are accepted: 0xBB starts a two-line read and 0xEB starts a four-line read. After the opcode the block collects a 24-bit address and an 8-bit mode byte over the chosen lines. A four-line read then waits through a fixed number of dummy clocks. After that the block drives array bytes onto the lines for as long as chip select stays low. Each clock enable in the description below is one serial clock, that is, one rising edge of `clk` while `cs_n` is low.

The mode byte also controls a sticky continuous-read state. If its high nibble is 0xA and the byte is not one of the escape codes, the next transaction has no opcode. It starts directly with the address phase and uses the lane width of the read that set the state. The state stays set until the mode position carries 0xFF, 0x00, 0xAA or 0x55. Any other mode byte leaves it as it is. The array itself is outside this block. The block drives `mem_addr` and expects the byte at that address on `mem_rdata` within the same cycle.

Top module: `mio_read_seq`

## Requirements
- R1: After reset the sequencer drives no line (`sio_oe` = 0000) and the continuous-read state is off, so the first transaction must begin with an opcode.
- R2: Opcode 0xBB, sent MSB first on line 0 over 8 clocks, selects a two-line read. The 24 address bits follow, MSB first, over 12 clocks. In each clock the higher bit of the pair is on line 1 and the lower bit is on line 0.
- R3: In a two-line read, the mode byte takes 4 clocks and no dummy clocks follow. From the next clock on, each byte goes out MSB first on lines 1:0 over 4 clocks, with the higher bit of each pair on line 1.
- R4: Opcode 0xEB selects a four-line read. The address takes 6 clocks and the mode byte 2 clocks, with line 3 carrying the most significant bit of each nibble. Then 4 dummy clocks pass. Each byte goes out high nibble first over 2 clocks, with line 3 as the MSB.
- R5: During the opcode, address, mode and dummy clocks all lines are inputs (`sio_oe` = 0000). In the data phase `sio_oe` is 0011 for a two-line read and 1111 for a four-line read.
- R6: The read address advances by one after each complete output byte and wraps from 0xFFFFFF to 0x000000.
- R7: Output continues byte after byte for as long as `cs_n` is low. `sio_oe` returns to 0000 in the same cycle that `cs_n` is high.
- R8: A mode byte whose high nibble is 0xA, and which is not an escape code, turns the continuous-read state on. The next transaction then starts at its address phase with the same lane width.
- R9: A mode byte of 0xFF, 0x00, 0xAA or 0x55 turns the continuous-read state off. The escape takes priority over the 0xA nibble, so 0xAA clears the state.
- R10: A mode byte that is neither an escape code nor of the 0xA high-nibble pattern leaves the continuous-read state unchanged, whether it is on or off.
- R11: Any opcode other than 0xBB or 0xEB leaves all lines as inputs until `cs_n` rises, and does not change the continuous-read state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Active-low chip select; high ends the transaction |
| sio_in | input | 4 | Values seen on the four data lines |
| sio_out | output | 4 | Values driven onto the data lines in the data phase |
| sio_oe | output | 4 | Per-line output enable, 1 = block drives the line |
| mem_addr | output | 24 | Current array read address |
| mem_rdata | input | 8 | Array byte at `mem_addr`, valid in the same cycle |

## Verification
The hardest case to reach from the ports is the continuous-read state. It is invisible, and it only shows up as a change in how the next transaction is framed. The bench therefore chains transactions. It sets the state with one mode byte and then sends opcode-less transactions. It feeds in a neutral mode byte to show that the state persists, and then an escape code. Finally it sends a normal transaction with an opcode. If the state had failed to clear, the opcode bits would be read as address bits and the returned data would not match. The escape 0xAA, which also carries the entering nibble, is run in a two-line chain so that the priority between the two rules is exercised.

// File: rtl/mio_pkg.sv
`timescale 1ns/1ps
package mio_pkg;

  typedef enum logic [2:0] {
    PH_CMD   = 3'd0,
    PH_ADDR  = 3'd1,
    PH_MODE  = 3'd2,
    PH_DUMMY = 3'd3,
    PH_DATA  = 3'd4,
    PH_SKIP  = 3'd5
  } mio_phase_e;

  typedef enum logic [1:0] {
    LN_ONE  = 2'd0,
    LN_TWO  = 2'd1,
    LN_FOUR = 2'd2
  } mio_lanes_e;

  localparam logic [7:0] OPC_DUAL_RD = 8'hBB;
  localparam logic [7:0] OPC_QUAD_RD = 8'hEB;

  // mode-position values that always leave continuous-read state
  function automatic logic is_escape(input logic [7:0] m);
    return (m == 8'hFF) || (m == 8'h00) || (m == 8'hAA) || (m == 8'h55);
  endfunction

endpackage

// File: rtl/mio_shift_in.sv
`timescale 1ns/1ps
module mio_shift_in
  import mio_pkg::*;
#(
  parameter int SH_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  mio_lanes_e       lanes,
  input  logic [3:0]       sio_in,
  output logic [SH_W-1:0]  word
);

  logic [SH_W-2:0] sh_q;
  logic [SH_W-2:0] sh_d;

  // word already includes the bits arriving this clock
  always_comb begin
    unique case (lanes)
      LN_ONE:  word = {sh_q[SH_W-2:0], sio_in[0]};
      LN_TWO:  word = {sh_q[SH_W-3:0], sio_in[1], sio_in[0]};
      default: word = {sh_q[SH_W-5:0], sio_in[3], sio_in[2], sio_in[1], sio_in[0]};
    endcase
  end

  always_comb begin
    sh_d = sh_q;
    if (en) sh_d = word[SH_W-2:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

endmodule

// File: rtl/mio_phase_ctrl.sv
`timescale 1ns/1ps
module mio_phase_ctrl
  import mio_pkg::*;
#(
  parameter int ADDR_BITS  = 24,
  parameter int DUAL_DUMMY = 0,
  parameter int QUAD_DUMMY = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       enh,
  input  logic [7:0] cmd_byte,
  output mio_phase_e phase,
  output mio_lanes_e lanes,
  output mio_lanes_e shift_lanes,
  output logic       shift_en,
  output logic       addr_done,
  output logic       mode_done
);

  localparam int L_A  = ADDR_BITS / 2;
  localparam int L_D  = (QUAD_DUMMY > DUAL_DUMMY) ? QUAD_DUMMY : DUAL_DUMMY;
  localparam int L_M  = (L_A > L_D) ? L_A : L_D;
  localparam int MAXL = (L_M > 8) ? L_M : 8;
  localparam int CW   = $clog2(MAXL + 1);

  mio_phase_e     phase_q, phase_d;
  mio_lanes_e     lanes_q, lanes_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [CW-1:0]  len;
  logic [CW-1:0]  dummy_len;
  logic           quad;
  logic           last;

  assign quad      = (lanes_q == LN_FOUR);
  assign dummy_len = quad ? CW'(QUAD_DUMMY) : CW'(DUAL_DUMMY);

  always_comb begin
    unique case (phase_q)
      PH_CMD:   len = CW'(8);
      PH_ADDR:  len = quad ? CW'(ADDR_BITS / 4) : CW'(ADDR_BITS / 2);
      PH_MODE:  len = quad ? CW'(2) : CW'(4);
      PH_DUMMY: len = dummy_len;
      default:  len = '0;
    endcase
  end

  assign last = (cnt_q == len - 1'b1);

  always_comb begin
    phase_d = phase_q;
    lanes_d = lanes_q;
    cnt_d   = cnt_q;
    if (cs_n) begin
      phase_d = enh ? PH_ADDR : PH_CMD;
      cnt_d   = '0;
    end else begin
      unique case (phase_q)
        PH_CMD: begin
          if (last) begin
            cnt_d = '0;
            if (cmd_byte == OPC_DUAL_RD) begin
              lanes_d = LN_TWO;
              phase_d = PH_ADDR;
            end else if (cmd_byte == OPC_QUAD_RD) begin
              lanes_d = LN_FOUR;
              phase_d = PH_ADDR;
            end else begin
              phase_d = PH_SKIP;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_ADDR: begin
          if (last) begin
            cnt_d   = '0;
            phase_d = PH_MODE;
          end else cnt_d = cnt_q + 1'b1;
        end
        PH_MODE: begin
          if (last) begin
            cnt_d   = '0;
            phase_d = (dummy_len == '0) ? PH_DATA : PH_DUMMY;
          end else cnt_d = cnt_q + 1'b1;
        end
        PH_DUMMY: begin
          if (last) begin
            cnt_d   = '0;
            phase_d = PH_DATA;
          end else cnt_d = cnt_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_CMD;
      lanes_q <= LN_TWO;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      lanes_q <= lanes_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase       = phase_q;
  assign lanes       = lanes_q;
  assign shift_lanes = (phase_q == PH_CMD) ? LN_ONE : lanes_q;
  assign shift_en    = !cs_n && (phase_q == PH_CMD || phase_q == PH_ADDR || phase_q == PH_MODE);
  assign addr_done   = !cs_n && (phase_q == PH_ADDR) && last;
  assign mode_done   = !cs_n && (phase_q == PH_MODE) && last;

  // R2: opcode phase lasts its full eight clocks
  p_cmd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && phase_q == PH_CMD && cnt_q != CW'(7)) |=> (phase_q == PH_CMD));

  // R7: a high chip select restarts framing from the first clock
  p_cs_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> ((phase_q == PH_CMD || phase_q == PH_ADDR) && cnt_q == '0));

endmodule

// File: rtl/mio_enh_track.sv
`timescale 1ns/1ps
module mio_enh_track
  import mio_pkg::*;
#(
  parameter logic [3:0] ENH_NIBBLE = 4'hA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_done,
  input  logic [7:0] mode_byte,
  output logic       enh
);

  logic enh_q, enh_d;

  always_comb begin
    enh_d = enh_q;
    if (mode_done) begin
      if (is_escape(mode_byte))                enh_d = 1'b0;
      else if (mode_byte[7:4] == ENH_NIBBLE)   enh_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) enh_q <= 1'b0;
    else        enh_q <= enh_d;
  end

  assign enh = enh_q;

  p_enter_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_done && !is_escape(mode_byte) && mode_byte[7:4] == ENH_NIBBLE) |=> enh);

  p_escape_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_done && is_escape(mode_byte)) |=> !enh);

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_done |=> $stable(enh));

endmodule

// File: rtl/mio_read_path.sv
`timescale 1ns/1ps
module mio_read_path
  import mio_pkg::*;
#(
  parameter int MEM_AW = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load,
  input  logic [MEM_AW-1:0] addr_in,
  input  logic              data_en,
  input  mio_lanes_e        lanes,
  input  logic [7:0]        mem_rdata,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [3:0]        sio_out,
  output logic [3:0]        sio_oe
);

  logic [MEM_AW-1:0] addr_q, addr_d;
  logic [1:0]        beat_q, beat_d;
  logic              quad;
  logic              byte_end;

  assign quad     = (lanes == LN_FOUR);
  assign byte_end = quad ? (beat_q == 2'd1) : (beat_q == 2'd3);

  always_comb begin
    addr_d = addr_q;
    beat_d = beat_q;
    if (addr_load) addr_d = addr_in;
    if (!data_en) begin
      beat_d = '0;
    end else if (byte_end) begin
      beat_d = '0;
      addr_d = addr_q + 1'b1;
    end else begin
      beat_d = beat_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      beat_q <= '0;
    end else begin
      addr_q <= addr_d;
      beat_q <= beat_d;
    end
  end

  always_comb begin
    if (quad) begin
      sio_out = beat_q[0] ? mem_rdata[3:0] : mem_rdata[7:4];
    end else begin
      unique case (beat_q)
        2'd0:    sio_out = {2'b00, mem_rdata[7:6]};
        2'd1:    sio_out = {2'b00, mem_rdata[5:4]};
        2'd2:    sio_out = {2'b00, mem_rdata[3:2]};
        default: sio_out = {2'b00, mem_rdata[1:0]};
      endcase
    end
  end

  assign sio_oe   = data_en ? (quad ? 4'hF : 4'h3) : 4'h0;
  assign mem_addr = addr_q;

  // R6: one step per finished byte, wrapping in the array width
  p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_en && byte_end && !addr_load) |=> (mem_addr == MEM_AW'($past(mem_addr) + 1'b1)));

endmodule

// File: rtl/mio_read_seq.sv
`timescale 1ns/1ps
module mio_read_seq
  import mio_pkg::*;
#(
  parameter int         ADDR_BITS  = 24,
  parameter int         MEM_AW     = 24,
  parameter int         DUAL_DUMMY = 0,
  parameter int         QUAD_DUMMY = 4,
  parameter logic [3:0] ENH_NIBBLE = 4'hA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic [3:0]        sio_in,
  output logic [3:0]        sio_out,
  output logic [3:0]        sio_oe,
  output logic [MEM_AW-1:0] mem_addr,
  input  logic [7:0]        mem_rdata
);

  logic              rst_meta_q, rst_sync_q;
  logic              rst_sync_n;
  mio_phase_e        phase;
  mio_lanes_e        lanes;
  mio_lanes_e        shift_lanes;
  logic              shift_en;
  logic              addr_done;
  logic              mode_done;
  logic              enh;
  logic              data_en;
  logic [ADDR_BITS-1:0] word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  assign rst_sync_n = rst_sync_q;

  mio_shift_in #(.SH_W(ADDR_BITS)) u_shift (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .en     (shift_en),
    .lanes  (shift_lanes),
    .sio_in (sio_in),
    .word   (word)
  );

  mio_phase_ctrl #(
    .ADDR_BITS  (ADDR_BITS),
    .DUAL_DUMMY (DUAL_DUMMY),
    .QUAD_DUMMY (QUAD_DUMMY)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .cs_n        (cs_n),
    .enh         (enh),
    .cmd_byte    (word[7:0]),
    .phase       (phase),
    .lanes       (lanes),
    .shift_lanes (shift_lanes),
    .shift_en    (shift_en),
    .addr_done   (addr_done),
    .mode_done   (mode_done)
  );

  mio_enh_track #(.ENH_NIBBLE(ENH_NIBBLE)) u_enh (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .mode_done (mode_done),
    .mode_byte (word[7:0]),
    .enh       (enh)
  );

  assign data_en = (phase == PH_DATA) && !cs_n;

  mio_read_path #(.MEM_AW(MEM_AW)) u_path (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .addr_load (addr_done),
    .addr_in   (word[MEM_AW-1:0]),
    .data_en   (data_en),
    .lanes     (lanes),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .sio_out   (sio_out),
    .sio_oe    (sio_oe)
  );

  // R5: lines are inputs outside the data phase
  p_quiet_lines_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (phase != PH_DATA) |-> (sio_oe == 4'h0));

  // R5: four-line data phase drives every line
  p_quad_lanes_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (phase == PH_DATA && !cs_n && lanes == LN_FOUR) |-> (sio_oe == 4'hF));

  // R11: a rejected opcode keeps every line released
  p_skip_quiet_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (phase == PH_SKIP) |-> (sio_oe == 4'h0));

endmodule

// File: tb/mio_read_seq_tb.sv
`timescale 1ns/1ps
module mio_read_seq_tb;

  logic        clk;
  logic        rst_n;
  logic        cs_n;
  logic [3:0]  sio_in;
  logic [3:0]  sio_out;
  logic [3:0]  sio_oe;
  logic [23:0] mem_addr;
  logic [7:0]  mem_rdata;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h6D;
  endfunction

  assign mem_rdata = mem_byte(mem_addr);

  mio_read_seq u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sio_in    (sio_in),
    .sio_out   (sio_out),
    .sio_oe    (sio_oe),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata)
  );

  task automatic chk(input string req, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // one full read transaction; every data beat is compared
  task automatic xfer(input string tag, input bit send_cmd, input logic [7:0] op,
                      input bit quad, input logic [23:0] addr, input logic [7:0] mode,
                      input int nbytes);
    int quiet_bad = 0;
    logic [3:0] mask = quad ? 4'hF : 4'h3;
    if (send_cmd) begin
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if (sio_oe !== 4'h0) quiet_bad++;
        cs_n = 1'b0;
        sio_in = {3'b000, op[7-i]};
      end
    end
    for (int k = 0; k < (quad ? 6 : 12); k++) begin
      @(negedge clk);
      if (sio_oe !== 4'h0) quiet_bad++;
      cs_n = 1'b0;
      sio_in = quad ? addr[23-4*k -: 4] : {2'b00, addr[23-2*k -: 2]};
    end
    for (int k = 0; k < (quad ? 2 : 4); k++) begin
      @(negedge clk);
      if (sio_oe !== 4'h0) quiet_bad++;
      sio_in = quad ? mode[7-4*k -: 4] : {2'b00, mode[7-2*k -: 2]};
    end
    for (int k = 0; k < (quad ? 4 : 0); k++) begin
      @(negedge clk);
      if (sio_oe !== 4'h0) quiet_bad++;
      sio_in = 4'h0;
    end
    chk("R5 lines released before data", quiet_bad == 0, quiet_bad, 0);
    for (int b = 0; b < nbytes; b++) begin
      logic [7:0] exp_b = mem_byte(addr + 24'(b));
      for (int k = 0; k < (quad ? 2 : 4); k++) begin
        logic [3:0] expv = quad ? exp_b[7-4*k -: 4] : {2'b00, exp_b[7-2*k -: 2]};
        @(negedge clk);
        sio_in = 4'h0;
        if (k == 0) chk("R5 data-phase enables", sio_oe === mask, sio_oe, mask);
        chk(tag, (sio_out & mask) === expv, sio_out & mask, expv);
      end
    end
    @(negedge clk);
    cs_n = 1'b1;
    #1;
    chk("R7 release on chip select high", sio_oe === 4'h0, sio_oe, 0);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cs_n = 1'b1; sio_in = 4'h0;
    repeat (4) @(negedge clk);
    chk("R1 reset lines released", sio_oe === 4'h0, sio_oe, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 lines released after reset", sio_oe === 4'h0, sio_oe, 0);
  endtask

  task automatic t_dual_basic();
    // first read after reset needs an opcode (R1)
    xfer("R1 R2 R3 dual data", 1'b1, 8'hBB, 1'b0, 24'h123456, 8'h00, 3);
  endtask

  task automatic t_quad_basic();
    xfer("R4 quad data", 1'b1, 8'hEB, 1'b1, 24'h00ABCD, 8'hFF, 3);
  endtask

  task automatic t_wrap();
    xfer("R6 quad wrap", 1'b1, 8'hEB, 1'b1, 24'hFFFFFF, 8'h00, 2);
    xfer("R6 dual wrap", 1'b1, 8'hBB, 1'b0, 24'hFFFFFE, 8'h00, 3);
  endtask

  task automatic t_long();
    xfer("R7 continuous output", 1'b1, 8'hEB, 1'b1, 24'h4000F0, 8'h00, 9);
  endtask

  task automatic t_enh_quad();
    xfer("R8 enter quad", 1'b1, 8'hEB, 1'b1, 24'h010203, 8'hA5, 2);
    xfer("R8 no opcode quad", 1'b0, 8'h00, 1'b1, 24'h777000, 8'h3C, 2);
    xfer("R10 state kept", 1'b0, 8'h00, 1'b1, 24'h00FF00, 8'h55, 2);
    xfer("R9 opcode after escape 0x55", 1'b1, 8'hBB, 1'b0, 24'h246810, 8'h00, 2);
  endtask

  task automatic t_enh_dual();
    xfer("R8 enter dual", 1'b1, 8'hBB, 1'b0, 24'h135790, 8'hA0, 2);
    xfer("R8 no opcode dual", 1'b0, 8'h00, 1'b0, 24'hC0FFEE, 8'hAA, 2);
    xfer("R9 opcode after escape 0xAA", 1'b1, 8'hEB, 1'b1, 24'h0A0B0C, 8'hFF, 2);
  endtask

  task automatic t_neutral_off();
    xfer("R10 neutral byte while off", 1'b1, 8'hBB, 1'b0, 24'h314159, 8'h3C, 1);
    xfer("R10 opcode still required", 1'b1, 8'hEB, 1'b1, 24'h271828, 8'h00, 2);
  endtask

  task automatic t_bad_opcode();
    int loud = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      cs_n = 1'b0;
      sio_in = {3'b000, 8'h9F >> (7 - i)} & 4'h1;
    end
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (sio_oe !== 4'h0) loud++;
      sio_in = 4'(i);
    end
    chk("R11 unknown opcode keeps lines released", loud == 0, loud, 0);
    @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
    xfer("R11 next opcode decoded", 1'b1, 8'hBB, 1'b0, 24'h00C0DE, 8'h00, 2);
  endtask

  initial begin
    t_reset();
    t_dual_basic();
    t_quad_basic();
    t_wrap();
    t_long();
    t_enh_quad();
    t_enh_dual();
    t_neutral_off();
    t_bad_opcode();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule